// File: doc/BRIEF.md
# AXI-Lite Request Master with Channel Watchdogs

This block is a single-beat AXI4-Lite style bus master that sits in the system clock domain. It takes request records (address, write data, byte strobes, transfer size and a read/write flag) from a first-word-fall-through input queue and pops them one at a time. A read drives the read-address channel and then takes the read data. A write presents the write-address and write-data channels together and then takes the write response. When a transaction ends, one response record (read data plus a 4-bit status code) is pushed into an output queue.

Each of the five channels has its own watchdog. The watchdog counts consecutive cycles in which the block waits on a handshake. If a wait lasts longer than a parameterised limit, the transaction is abandoned and a channel-specific timeout code is reported. The master then issues nothing more until it is reset.

A counter of popped-but-unanswered requests drives a busy flag. The live status output shows idle, running, or the code of the last finished transaction. The transaction ID is a constant parameter. The size field uses the usual AXI encoding, in which a transfer carries 2^size bytes.

Top module: `axil_req_master`

## Requirements
- R1: While reset is held and right after it, all AXI valid and ready outputs, `req_pop_o`, `rsp_push_o` and `busy_o` are 0, and `status_o` is 0 (idle).
- R2: `req_pop_o` is raised only when the block is not busy and `req_empty_i` is 0. Requests are handled strictly one at a time and in order. `busy_o` is 1 from the cycle after the pop until the cycle after that request's response push.
- R3: A read raises `m_arvalid_o` with the request address, size and ID `TXN_ID`, and holds address and valid until `m_arready_i`. `m_rready_o` is raised only after the read-address handshake.
- R4: A write raises `m_awvalid_o` and `m_wvalid_o` together, carrying the address, size, ID `TXN_ID`, data and strobes. Each valid drops after its own handshake. `m_bready_o` is raised only after both handshakes.
- R5: Response codes 0, 1, 2 and 3 (OKAY, EXOKAY, SLVERR, DECERR) become status 7, 8, 9 and 10. The response record carries the read data for a read, and zero for a write or a timeout.
- R6: The block pushes exactly one response record per popped request. It never pushes while `rsp_full_i` is 1, and holds the record until the queue has room.
- R7: A wait on one channel of more than `TIMEOUT_CYC` consecutive cycles ends the transaction. The waiting signal stays high for exactly `TIMEOUT_CYC`+1 cycles, then all valid and ready outputs drop. The status becomes 2 (AR), 3 (R), 4 (AW), 5 (W) or 6 (B).
- R8: After a timeout response is pushed, no further request is popped until reset, and `status_o` keeps the timeout code.
- R9: `status_o` becomes 1 (running) in the cycle after a pop. It shows the result code from the cycle after the completing handshake (or timeout), holds it until the next pop, and never exceeds 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_empty_i | input | 1 | Request queue is empty |
| req_pop_o | output | 1 | Pop the head request this cycle |
| req_addr_i | input | ADDR_W | Head request address |
| req_wdata_i | input | DATA_W | Head request write data |
| req_wstrb_i | input | DATA_W/8 | Head request byte strobes |
| req_size_i | input | 3 | Head request size (2^size bytes) |
| req_write_i | input | 1 | Head request is a write (1) or read (0) |
| rsp_full_i | input | 1 | Response queue is full |
| rsp_push_o | output | 1 | Push a response record this cycle |
| rsp_rdata_o | output | DATA_W | Response record data |
| busy_o | output | 1 | A popped request is still unanswered |
| status_o | output | 4 | Live status, also the response record code |
| m_arid_o | output | ID_W | Read-address ID |
| m_araddr_o | output | ADDR_W | Read address |
| m_arsize_o | output | 3 | Read size |
| m_arvalid_o | output | 1 | Read-address valid |
| m_arready_i | input | 1 | Read-address ready |
| m_rdata_i | input | DATA_W | Read data |
| m_rresp_i | input | 2 | Read response |
| m_rvalid_i | input | 1 | Read-data valid |
| m_rready_o | output | 1 | Read-data ready |
| m_awid_o | output | ID_W | Write-address ID |
| m_awaddr_o | output | ADDR_W | Write address |
| m_awsize_o | output | 3 | Write size |
| m_awvalid_o | output | 1 | Write-address valid |
| m_awready_i | input | 1 | Write-address ready |
| m_wdata_o | output | DATA_W | Write data |
| m_wstrb_o | output | DATA_W/8 | Write strobes |
| m_wvalid_o | output | 1 | Write-data valid |
| m_wready_i | input | 1 | Write-data ready |
| m_bresp_i | input | 2 | Write response |
| m_bvalid_i | input | 1 | Write-response valid |
| m_bready_o | output | 1 | Write-response ready |

## Verification
A request is consumed at the clock edge where `req_pop_o` is high. The first address valid and `status_o` = 1 appear one cycle later. The result code appears one cycle after the completing response handshake, and the push happens in that same cycle if the queue has room. `busy_o` falls one cycle after the push. On a timeout, the waiting signal is high for `TIMEOUT_CYC`+1 cycles. The bench drives inputs just after an edge and samples outputs on the falling edge. It waits for `req_pop_o` and `rsp_push_o` with bounded loops and counts cycles per channel, so every comparison falls in the cycle these latencies predict, across a sweep of response codes, slave latencies, strobes and sizes.

// File: rtl/axil_mst_pkg.sv
`timescale 1ns/1ps
package axil_mst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RADDR,
        ST_RDATA,
        ST_WADDR,
        ST_WRESP,
        ST_REPLY,
        ST_HALT
    } mst_state_e;

    localparam int NUM_CHAN = 5;
    localparam int CH_AR    = 0;
    localparam int CH_R     = 1;
    localparam int CH_AW    = 2;
    localparam int CH_W     = 3;
    localparam int CH_B     = 4;

    localparam logic [3:0] CODE_IDLE     = 4'd0;
    localparam logic [3:0] CODE_RUN      = 4'd1;
    localparam logic [3:0] CODE_TMO_BASE = 4'd2;
    localparam logic [3:0] CODE_RSP_BASE = 4'd7;

    function automatic logic [3:0] tmo_code(input int unsigned ch);
        return CODE_TMO_BASE + 4'(ch);
    endfunction

    function automatic logic [3:0] rsp_code(input logic [1:0] resp);
        return CODE_RSP_BASE + {2'b00, resp};
    endfunction

    function automatic logic is_tmo(input logic [3:0] code);
        return (code >= CODE_TMO_BASE) && (code < CODE_RSP_BASE);
    endfunction

endpackage

// File: rtl/axil_chan_wdog.sv
`timescale 1ns/1ps
// Counts consecutive cycles spent waiting on one handshake; flags expiry
// in the cycle after LIMIT waiting cycles have gone by without completion.
module axil_chan_wdog #(
    parameter int LIMIT = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wait_i,
    output logic expire_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!wait_i) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = wait_i && (cnt_q == CNT_MAX);

endmodule

// File: rtl/axil_ot_count.sv
`timescale 1ns/1ps
// Outstanding-request counter: one up per pop, one down per response push.
module axil_ot_count #(
    parameter int MAX_OT = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic inc_i,
    input  logic dec_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(MAX_OT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(inc_i) - CNT_W'(dec_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/axil_req_master.sv
`timescale 1ns/1ps
module axil_req_master
    import axil_mst_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              DATA_W      = 32,
    parameter int              ID_W        = 4,
    parameter logic [ID_W-1:0] TXN_ID      = '0,
    parameter int              TIMEOUT_CYC = 1024,
    parameter int              MAX_OT      = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  req_empty_i,
    output logic                  req_pop_o,
    input  logic [ADDR_W-1:0]     req_addr_i,
    input  logic [DATA_W-1:0]     req_wdata_i,
    input  logic [DATA_W/8-1:0]   req_wstrb_i,
    input  logic [2:0]            req_size_i,
    input  logic                  req_write_i,
    input  logic                  rsp_full_i,
    output logic                  rsp_push_o,
    output logic [DATA_W-1:0]     rsp_rdata_o,
    output logic                  busy_o,
    output logic [3:0]            status_o,
    output logic [ID_W-1:0]       m_arid_o,
    output logic [ADDR_W-1:0]     m_araddr_o,
    output logic [2:0]            m_arsize_o,
    output logic                  m_arvalid_o,
    input  logic                  m_arready_i,
    input  logic [DATA_W-1:0]     m_rdata_i,
    input  logic [1:0]            m_rresp_i,
    input  logic                  m_rvalid_i,
    output logic                  m_rready_o,
    output logic [ID_W-1:0]       m_awid_o,
    output logic [ADDR_W-1:0]     m_awaddr_o,
    output logic [2:0]            m_awsize_o,
    output logic                  m_awvalid_o,
    input  logic                  m_awready_i,
    output logic [DATA_W-1:0]     m_wdata_o,
    output logic [DATA_W/8-1:0]   m_wstrb_o,
    output logic                  m_wvalid_o,
    input  logic                  m_wready_i,
    input  logic [1:0]            m_bresp_i,
    input  logic                  m_bvalid_i,
    output logic                  m_bready_o
);
    localparam int STRB_W = DATA_W / 8;

    typedef struct packed {
        mst_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic [STRB_W-1:0]   strb;
        logic [2:0]          size;
        logic                aw_done;
        logic                w_done;
        logic [3:0]          code;
    } mst_regs_t;

    mst_regs_t d, q;

    logic [NUM_CHAN-1:0] chan_wait;
    logic [NUM_CHAN-1:0] chan_expire;
    logic                pop, push;

    // Handshake waits per channel, in package channel order.
    assign chan_wait[CH_AR] = m_arvalid_o && !m_arready_i;
    assign chan_wait[CH_R]  = m_rready_o  && !m_rvalid_i;
    assign chan_wait[CH_AW] = m_awvalid_o && !m_awready_i;
    assign chan_wait[CH_W]  = m_wvalid_o  && !m_wready_i;
    assign chan_wait[CH_B]  = m_bready_o  && !m_bvalid_i;

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_wdog
        axil_chan_wdog #(
            .LIMIT    (TIMEOUT_CYC)
        ) i_wdog (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .wait_i   (chan_wait[ch]),
            .expire_o (chan_expire[ch])
        );
    end

    axil_ot_count #(
        .MAX_OT (MAX_OT)
    ) i_ot (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (pop),
        .dec_i  (push),
        .busy_o (busy_o)
    );

    always_comb begin
        logic aw_now, w_now;
        d      = q;
        pop    = 1'b0;
        push   = 1'b0;
        aw_now = 1'b0;
        w_now  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (!req_empty_i) begin
                    pop       = 1'b1;
                    d.addr    = req_addr_i;
                    d.data    = req_write_i ? req_wdata_i : '0;
                    d.strb    = req_wstrb_i;
                    d.size    = req_size_i;
                    d.aw_done = 1'b0;
                    d.w_done  = 1'b0;
                    d.code    = CODE_RUN;
                    d.st      = req_write_i ? ST_WADDR : ST_RADDR;
                end
            end
            ST_RADDR: begin
                if (m_arready_i) begin
                    d.st = ST_RDATA;
                end else if (chan_expire[CH_AR]) begin
                    d.code = tmo_code(CH_AR);
                    d.st   = ST_REPLY;
                end
            end
            ST_RDATA: begin
                if (m_rvalid_i) begin
                    d.data = m_rdata_i;
                    d.code = rsp_code(m_rresp_i);
                    d.st   = ST_REPLY;
                end else if (chan_expire[CH_R]) begin
                    d.code = tmo_code(CH_R);
                    d.st   = ST_REPLY;
                end
            end
            ST_WADDR: begin
                aw_now    = q.aw_done || m_awready_i;
                w_now     = q.w_done  || m_wready_i;
                d.aw_done = aw_now;
                d.w_done  = w_now;
                if (aw_now && w_now) begin
                    d.data = '0;
                    d.st   = ST_WRESP;
                end else if (chan_expire[CH_AW]) begin
                    d.data = '0;
                    d.code = tmo_code(CH_AW);
                    d.st   = ST_REPLY;
                end else if (chan_expire[CH_W]) begin
                    d.data = '0;
                    d.code = tmo_code(CH_W);
                    d.st   = ST_REPLY;
                end
            end
            ST_WRESP: begin
                if (m_bvalid_i) begin
                    d.code = rsp_code(m_bresp_i);
                    d.st   = ST_REPLY;
                end else if (chan_expire[CH_B]) begin
                    d.code = tmo_code(CH_B);
                    d.st   = ST_REPLY;
                end
            end
            ST_REPLY: begin
                if (!rsp_full_i) begin
                    push = 1'b1;
                    d.st = is_tmo(q.code) ? ST_HALT : ST_IDLE;
                end
            end
            default: begin
                d.st = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.st      <= ST_IDLE;
            q.addr    <= '0;
            q.data    <= '0;
            q.strb    <= '0;
            q.size    <= '0;
            q.aw_done <= 1'b0;
            q.w_done  <= 1'b0;
            q.code    <= CODE_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_pop_o   = pop;
    assign rsp_push_o  = push;
    assign rsp_rdata_o = q.data;
    assign status_o    = q.code;

    assign m_arid_o    = TXN_ID;
    assign m_araddr_o  = q.addr;
    assign m_arsize_o  = q.size;
    assign m_arvalid_o = (q.st == ST_RADDR);
    assign m_rready_o  = (q.st == ST_RDATA);

    assign m_awid_o    = TXN_ID;
    assign m_awaddr_o  = q.addr;
    assign m_awsize_o  = q.size;
    assign m_awvalid_o = (q.st == ST_WADDR) && !q.aw_done;
    assign m_wdata_o   = q.data;
    assign m_wstrb_o   = q.strb;
    assign m_wvalid_o  = (q.st == ST_WADDR) && !q.w_done;
    assign m_bready_o  = (q.st == ST_WRESP);

endmodule

module axil_req_master_chk
    import axil_mst_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_empty_i,
    input logic              req_pop_o,
    input logic              rsp_full_i,
    input logic              rsp_push_o,
    input logic              busy_o,
    input logic [3:0]        status_o,
    input logic [ADDR_W-1:0] m_araddr_o,
    input logic              m_arvalid_o,
    input logic              m_arready_i,
    input logic [1:0]        m_rresp_i,
    input logic              m_rvalid_i,
    input logic              m_rready_o,
    input logic              m_awvalid_o,
    input logic              m_awready_i,
    input logic              m_wvalid_o,
    input logic              m_wready_i,
    input logic [1:0]        m_bresp_i,
    input logic              m_bvalid_i,
    input logic              m_bready_o
);
    logic ar_seen, aw_seen, w_seen, halted;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ar_seen <= 1'b0;
            aw_seen <= 1'b0;
            w_seen  <= 1'b0;
            halted  <= 1'b0;
        end else begin
            if (m_arvalid_o && m_arready_i) ar_seen <= 1'b1;
            else if (rsp_push_o)            ar_seen <= 1'b0;
            if (m_awvalid_o && m_awready_i) aw_seen <= 1'b1;
            else if (rsp_push_o)            aw_seen <= 1'b0;
            if (m_wvalid_o && m_wready_i)   w_seen  <= 1'b1;
            else if (rsp_push_o)            w_seen  <= 1'b0;
            if (rsp_push_o && is_tmo(status_o)) halted <= 1'b1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (!m_arvalid_o && !m_awvalid_o && !m_wvalid_o && !busy_o && status_o == 4'd0));

    p_pop_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_pop_o |-> (!req_empty_i && !busy_o));

    p_rready_after_ar_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_rready_o |-> ar_seen);

    p_ar_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_arvalid_o && !m_arready_i) |=> ((m_arvalid_o && $stable(m_araddr_o)) || status_o == 4'd2));

    p_bready_after_aw_w_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_bready_o |-> (aw_seen && w_seen));

    p_rd_map_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_rvalid_i && m_rready_o) |=> status_o == (4'd7 + {2'b00, $past(m_rresp_i)}));

    p_wr_map_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_bvalid_i && m_bready_o) |=> status_o == (4'd7 + {2'b00, $past(m_bresp_i)}));

    p_push_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_push_o |-> !rsp_full_i);

    p_tmo_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_tmo(status_o) |-> (!m_arvalid_o && !m_rready_o && !m_awvalid_o && !m_wvalid_o && !m_bready_o));

    p_halt_no_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halted |-> !req_pop_o);

    p_pop_runs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_pop_o |=> (status_o == 4'd1 && busy_o));

    p_status_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o <= 4'd10);

endmodule

bind axil_req_master axil_req_master_chk #(
    .ADDR_W (ADDR_W)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_empty_i (req_empty_i),
    .req_pop_o   (req_pop_o),
    .rsp_full_i  (rsp_full_i),
    .rsp_push_o  (rsp_push_o),
    .busy_o      (busy_o),
    .status_o    (status_o),
    .m_araddr_o  (m_araddr_o),
    .m_arvalid_o (m_arvalid_o),
    .m_arready_i (m_arready_i),
    .m_rresp_i   (m_rresp_i),
    .m_rvalid_i  (m_rvalid_i),
    .m_rready_o  (m_rready_o),
    .m_awvalid_o (m_awvalid_o),
    .m_awready_i (m_awready_i),
    .m_wvalid_o  (m_wvalid_o),
    .m_wready_i  (m_wready_i),
    .m_bresp_i   (m_bresp_i),
    .m_bvalid_i  (m_bvalid_i),
    .m_bready_o  (m_bready_o)
);

// File: tb/test_axil_req_master.sv
`timescale 1ns/1ps
module test_axil_req_master;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int ID_W   = 2;
    localparam logic [ID_W-1:0] TID = 2'd2;
    localparam int TMO    = 8;
    localparam int NEVER  = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              req_empty = 1'b1, req_pop, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [3:0]        req_wstrb = '0;
    logic [2:0]        req_size = '0;
    logic              rsp_full = 1'b0, rsp_push, busy;
    logic [31:0]       rsp_rdata;
    logic [3:0]        status;
    logic [ID_W-1:0]   arid, awid;
    logic [ADDR_W-1:0] araddr, awaddr;
    logic [2:0]        arsize, awsize;
    logic              arvalid, arready, rvalid, rready;
    logic              awvalid, awready, wvalid, wready, bvalid, bready;
    logic [31:0]       rdata, wdata;
    logic [3:0]        wstrb;
    logic [1:0]        rresp, bresp;

    axil_req_master #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .TXN_ID(TID),
        .TIMEOUT_CYC(TMO), .MAX_OT(4)
    ) i_axil_req_master (
        .clk_i(clk), .rst_ni(rst_n),
        .req_empty_i(req_empty), .req_pop_o(req_pop), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .req_wstrb_i(req_wstrb), .req_size_i(req_size),
        .req_write_i(req_write), .rsp_full_i(rsp_full), .rsp_push_o(rsp_push),
        .rsp_rdata_o(rsp_rdata), .busy_o(busy), .status_o(status),
        .m_arid_o(arid), .m_araddr_o(araddr), .m_arsize_o(arsize),
        .m_arvalid_o(arvalid), .m_arready_i(arready),
        .m_rdata_i(rdata), .m_rresp_i(rresp), .m_rvalid_i(rvalid), .m_rready_o(rready),
        .m_awid_o(awid), .m_awaddr_o(awaddr), .m_awsize_o(awsize),
        .m_awvalid_o(awvalid), .m_awready_i(awready),
        .m_wdata_o(wdata), .m_wstrb_o(wstrb), .m_wvalid_o(wvalid), .m_wready_i(wready),
        .m_bresp_i(bresp), .m_bvalid_i(bvalid), .m_bready_o(bready)
    );

    // ---------------- slave model ----------------
    int ar_lat, r_lat, aw_lat, w_lat, b_lat;
    logic [1:0] resp_sel;
    logic [31:0] mem [16];
    int ar_cnt, r_cnt, aw_cnt, w_cnt, b_cnt;
    logic r_pend, b_pend, aw_got, w_got;
    logic [3:0] r_idx, aw_idx;
    logic [31:0] w_dat;
    logic [3:0]  w_stb;
    logic [2:0]  seen_awsize, seen_arsize;
    logic [ID_W-1:0] seen_awid, seen_arid;

    always @(posedge clk) begin
        if (!rst_n) begin
            arready <= 0; rvalid <= 0; awready <= 0; wready <= 0; bvalid <= 0;
            ar_cnt <= 0; r_cnt <= 0; aw_cnt <= 0; w_cnt <= 0; b_cnt <= 0;
            r_pend <= 0; b_pend <= 0; aw_got <= 0; w_got <= 0;
            rdata <= '0; rresp <= '0; bresp <= '0;
        end else begin
            if (arvalid && !arready) begin
                if (ar_cnt >= ar_lat) arready <= 1;
                ar_cnt <= ar_cnt + 1;
            end
            if (arvalid && arready) begin
                arready <= 0; ar_cnt <= 0; r_pend <= 1; r_cnt <= 0;
                r_idx <= araddr[5:2]; seen_arsize <= arsize; seen_arid <= arid;
            end
            if (r_pend) begin
                if (r_cnt >= r_lat) begin
                    rvalid <= 1; rdata <= mem[r_idx]; rresp <= resp_sel; r_pend <= 0;
                end else r_cnt <= r_cnt + 1;
            end
            if (rvalid && rready) rvalid <= 0;
            if (awvalid && !awready) begin
                if (aw_cnt >= aw_lat) awready <= 1;
                aw_cnt <= aw_cnt + 1;
            end
            if (awvalid && awready) begin
                awready <= 0; aw_cnt <= 0; aw_got <= 1;
                aw_idx <= awaddr[5:2]; seen_awsize <= awsize; seen_awid <= awid;
            end
            if (wvalid && !wready) begin
                if (w_cnt >= w_lat) wready <= 1;
                w_cnt <= w_cnt + 1;
            end
            if (wvalid && wready) begin
                wready <= 0; w_cnt <= 0; w_got <= 1; w_dat <= wdata; w_stb <= wstrb;
            end
            if (aw_got && w_got) begin
                for (int b = 0; b < 4; b++)
                    if (w_stb[b]) mem[aw_idx][8*b +: 8] <= w_dat[8*b +: 8];
                aw_got <= 0; w_got <= 0; b_pend <= 1; b_cnt <= 0;
            end
            if (b_pend) begin
                if (b_cnt >= b_lat) begin
                    bvalid <= 1; bresp <= resp_sel; b_pend <= 0;
                end else b_cnt <= b_cnt + 1;
            end
            if (bvalid && bready) bvalid <= 0;
        end
    end

    // ---------------- monitor ----------------
    int viol_r3 = 0, viol_r4 = 0, push_cnt = 0, pop_cnt = 0;
    int hang [5];
    logic mon_ar = 0, mon_aw = 0, mon_w = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mon_ar = 0; mon_aw = 0; mon_w = 0;
        end else begin
            if (rready && !mon_ar) viol_r3++;
            if (bready && !(mon_aw && mon_w)) viol_r4++;
            if (awvalid && !wvalid && !mon_w) viol_r4++;
            if (arvalid && arready) mon_ar = 1;
            if (rvalid && rready) mon_ar = 0;
            if (awvalid && awready) mon_aw = 1;
            if (wvalid && wready) mon_w = 1;
            if (bvalid && bready) begin mon_aw = 0; mon_w = 0; end
            if (arvalid) hang[0]++;
            if (rready)  hang[1]++;
            if (awvalid) hang[2]++;
            if (wvalid)  hang[3]++;
            if (bready)  hang[4]++;
            if (rsp_push) push_cnt++;
            if (req_pop) pop_cnt++;
        end
    end

    // ---------------- bookkeeping ----------------
    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] exp_mem [16];
    logic [3:0]  got_code;
    logic [31:0] got_rdata;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    task automatic do_reset();
        rst_n = 0; req_empty = 1; rsp_full = 0;
        ar_lat = 0; r_lat = 0; aw_lat = 0; w_lat = 0; b_lat = 0; resp_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic run_txn(input logic wr, input logic [7:0] a, input logic [31:0] dat,
                           input logic [3:0] s, input logic [2:0] sz, input int hold);
        int n;
        int p0, q0;
        for (int c = 0; c < 5; c++) hang[c] = 0;
        req_write = wr; req_addr = a; req_wdata = dat; req_wstrb = s; req_size = sz;
        req_empty = 0; rsp_full = (hold > 0);
        #1;
        n = 0;
        while (!req_pop && n < 100) begin @(negedge clk); #1; n++; end
        check("R2 pop seen", 64'(req_pop), 64'd1);
        @(posedge clk); #1;
        if (hold == 0) req_empty = 1;
        @(negedge clk);
        check("R2 busy after pop", 64'(busy), 64'd1);
        check("R9 running after pop", 64'(status), 64'd1);
        if (hold > 0) begin
            p0 = push_cnt; q0 = pop_cnt;
            repeat (hold) @(negedge clk);
            check("R6 no push while full", 64'(push_cnt), 64'(p0));
            check("R2 no second pop while busy", 64'(pop_cnt), 64'(q0));
            check("R2 busy held while full", 64'(busy), 64'd1);
            req_empty = 1; rsp_full = 0;
        end
        p0 = push_cnt;
        n = 0;
        while (!rsp_push && n < 300) begin @(negedge clk); n++; end
        got_code = status; got_rdata = rsp_rdata;
        @(negedge clk);
        check("R6 one push", 64'(push_cnt - p0), 64'd1);
        check("R2 idle after push", 64'(busy), 64'd0);
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] nw, input logic [3:0] s);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i] = 32'hA500_0000 + 32'(i) * 32'h0001_0203;
            exp_mem[i] = 32'hA500_0000 + 32'(i) * 32'h0001_0203;
        end
        for (int c = 0; c < 5; c++) hang[c] = 0;
        rst_n = 0;
        ar_lat = 0; r_lat = 0; aw_lat = 0; w_lat = 0; b_lat = 0; resp_sel = 0;
        repeat (2) @(negedge clk);
        // R1: during reset
        check("R1 arvalid in reset", 64'(arvalid | awvalid | wvalid), 64'd0);
        check("R1 ready outs in reset", 64'(rready | bready), 64'd0);
        check("R1 busy/pop in reset", 64'({busy, req_pop, rsp_push}), 64'd0);
        check("R1 status idle", 64'(status), 64'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1 status idle after reset", 64'(status), 64'd0);

        // Sweep: response codes x slave latencies, write then read back
        for (int rc = 0; rc < 4; rc++) begin
            for (int lat = 0; lat < 3; lat++) begin
                int idx;
                logic [31:0] dat;
                logic [3:0]  stb;
                logic [2:0]  sz;
                idx = rc * 3 + lat;
                dat = 32'h3C00_0000 ^ (32'(idx) * 32'h0101_1111);
                stb = 4'(idx + 1);
                sz  = 3'(idx % 3);
                ar_lat = lat; r_lat = (lat + 1) % 3; aw_lat = lat; w_lat = 2 - lat;
                b_lat = lat; resp_sel = 2'(rc);
                run_txn(1'b1, 8'(idx << 2), dat, stb, sz, 0);
                exp_mem[idx] = merge(exp_mem[idx], dat, stb);
                check("R5 write code", 64'(got_code), 64'(7 + rc));
                check("R5 write record data zero", 64'(got_rdata), 64'd0);
                check("R4 awsize", 64'(seen_awsize), 64'(sz));
                check("R4 awid", 64'(seen_awid), 64'(TID));
                check("R9 code held", 64'(status), 64'(7 + rc));
                run_txn(1'b0, 8'(idx << 2), 32'hFFFF_FFFF, 4'h0, sz, 0);
                check("R5 read code", 64'(got_code), 64'(7 + rc));
                check("R3 read data", 64'(got_rdata), 64'(exp_mem[idx]));
                check("R3 arsize", 64'(seen_arsize), 64'(sz));
                check("R3 arid", 64'(seen_arid), 64'(TID));
            end
        end

        // R6: response queue full for a while
        ar_lat = 1; r_lat = 1; resp_sel = 2'd0;
        run_txn(1'b0, 8'h0C, 32'h0, 4'h0, 3'd2, 30);
        check("R6 code after backpressure", 64'(got_code), 64'd7);
        check("R6 data after backpressure", 64'(got_rdata), 64'(exp_mem[3]));

        check("R3 rready only after AR handshake", 64'(viol_r3), 64'd0);
        check("R4 bready after AW+W, valids together", 64'(viol_r4), 64'd0);

        // R7/R8: a hang on each channel in turn
        for (int ch = 0; ch < 5; ch++) begin
            int p0;
            do_reset();
            if (ch == 0) ar_lat = NEVER;
            if (ch == 1) r_lat  = NEVER;
            if (ch == 2) aw_lat = NEVER;
            if (ch == 3) w_lat  = NEVER;
            if (ch == 4) b_lat  = NEVER;
            run_txn(ch >= 2, 8'h10, 32'h1234_5678, 4'hF, 3'd2, 0);
            check($sformatf("R7 timeout code ch%0d", ch), 64'(got_code), 64'(2 + ch));
            check($sformatf("R7 wait length ch%0d", ch), 64'(hang[ch]), 64'(TMO + 1));
            check("R7 timeout record data zero", 64'(got_rdata), 64'd0);
            check("R7 outputs quiet", 64'({arvalid, rready, awvalid, wvalid, bready}), 64'd0);
            p0 = pop_cnt;
            req_empty = 0;
            repeat (20) @(negedge clk);
            check("R8 no pop after timeout", 64'(pop_cnt), 64'(p0));
            check("R8 status keeps code", 64'(status), 64'(2 + ch));
            req_empty = 1;
        end

        // R1 again: reset clears the halted state
        do_reset();
        check("R1 status idle after second reset", 64'(status), 64'd0);
        run_txn(1'b0, 8'h04, 32'h0, 4'h0, 3'd2, 0);
        check("R8 pops again after reset", 64'(got_code), 64'd7);

        finish_run();
    end

endmodule